// File: doc/BRIEF.md
# Cache-as-RAM Address Mapping Unit

This unit sits beside a data cache and lets the upper half of the cache entry index range serve as directly addressed on-chip RAM. With the RAM enable set, CPU requests whose address falls in a fixed window map straight onto cache storage coordinates: entry index, way, 8-byte word within the line, and byte lane enables. These requests bypass tag lookup. Requests outside the window, or any request while the enable is clear, are handed to the normal cache path.

With a single way in use the RAM holds 8 KB and repeats every 8 KB across the window. With both ways in use the RAM holds 16 KB: address bit 13 picks the way, so the image repeats every 16 KB. Instruction fetches into the window, misaligned accesses, and the illegal pairing of RAM mode with index-mode addressing are reported as errors and never write. The unit also filters the victim index chosen by the cache's replacement logic, so that entries in the RAM half are never allocated while RAM mode is on.

Top module: `car_map_top`

## Requirements
- R1: A valid request whose address lies in 0x7C00_0000..0x7FFF_FFFF while the RAM enable is set is a RAM access. Any other valid request raises `pass_o`. `hit_o` and `pass_o` are never high together.
- R2: On a RAM hit, the entry index is 256 + address bits [12:5] and the word select is address bits [4:3]. The RAM therefore repeats every 8 KB across the window.
- R3: With both ways in use, a hit selects way = address bit 13, which gives a 16 KB repeat period. With a single way in use, the way output is always 0.
- R4: Size codes are 0 byte, 1 word, 2 longword and 3 quadword. A hit enables 2^size consecutive lanes of the 8 lanes, starting at lane address[2:0]. `wr_en_o` equals the write flag of the hit.
- R5: A RAM access whose address is not a multiple of its size raises `addr_err_o`. That access has no hit, no lanes and no write.
- R6: An instruction fetch that is a RAM access raises `fetch_err_o` and never hits.
- R7: RAM enable together with index mode raises `cfg_err_o`. While both are set, no RAM access hits.
- R8: While RAM enable is set, `alloc_idx_o` equals `alloc_idx_i` with its top bit cleared. Otherwise the index passes through unchanged. This path is combinational.
- R9: All registered outputs are 0 during reset. A request's results appear one clock edge after it is presented.
- R10: With RAM enable clear, window addresses pass to the cache and raise no hit and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ram_en_i | input | 1 | RAM mode enable |
| dbl_mode_i | input | 1 | Both ways used (16 KB RAM) |
| idx_mode_i | input | 1 | Index-mode addressing active |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 32 | Request address |
| req_size_i | input | 2 | Size code (0 byte .. 3 quad) |
| req_fetch_i | input | 1 | Request is an instruction fetch |
| req_write_i | input | 1 | Request is a write |
| alloc_idx_i | input | 9 | Victim index from replacement logic |
| alloc_idx_o | output | 9 | Filtered victim index |
| pass_o | output | 1 | Request goes to the cache path |
| hit_o | output | 1 | Valid RAM access |
| wr_en_o | output | 1 | RAM write |
| ram_way_o | output | 1 | Way selected |
| ram_idx_o | output | 9 | Entry index selected |
| word_sel_o | output | 2 | 8-byte word within the line |
| lane_en_o | output | 8 | Byte lane enables |
| fetch_err_o | output | 1 | Fetch into RAM window |
| addr_err_o | output | 1 | Misaligned RAM access |
| cfg_err_o | output | 1 | RAM mode with index mode |

## Verification
Some rules are checked on every cycle by the assertions. The victim index never reaches the RAM half while RAM mode is on. Hits and pass-throughs never overlap. Every error leaves the lanes and the write strobe quiet. A hit always lands in the upper index half. The single-way mode never picks way 1. The exact arithmetic can only be shown by the bench sweeps, which walk every size and offset across several window bases in both capacity modes. That arithmetic covers the index and word values, the alias periods, the lane patterns, and which unaligned offsets fail.

// File: rtl/car_pkg.sv
package car_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } size_e;
endpackage

// File: rtl/car_win_dec.sv
module car_win_dec #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_LO = 32'h7C00_0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'h7FFF_FFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_win_o
);
  assign in_win_o = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);
endmodule

// File: rtl/car_lane_gen.sv
module car_lane_gen #(
  parameter int unsigned LANES = 8,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [LANE_W-1:0] off_i,
  input  car_pkg::size_e    size_i,
  output logic [LANES-1:0]  lane_en_o,
  output logic              misalign_o
);
  logic [LANE_W:0] nbytes;
  logic [LANE_W:0] off_ext;
  logic [LANE_W:0] end_ext;

  assign nbytes  = (LANE_W+1)'(1) << size_i;
  assign off_ext = {1'b0, off_i};
  assign end_ext = off_ext + nbytes;

  assign misalign_o = |(off_ext & (nbytes - (LANE_W+1)'(1)));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en_o[l] = ((LANE_W+1)'(l) >= off_ext) && ((LANE_W+1)'(l) < end_ext);
  end
endmodule

// File: rtl/car_idx_map.sv
module car_idx_map #(
  parameter int unsigned HALF_W = 8
) (
  input  logic [HALF_W:0] sel_i,  // address bits above line offset, top bit picks way
  input  logic            dbl_i,
  output logic [HALF_W:0] idx_o,
  output logic            way_o
);
  assign idx_o = {1'b1, sel_i[HALF_W-1:0]};
  assign way_o = dbl_i & sel_i[HALF_W];
endmodule

// File: rtl/car_alloc_guard.sv
module car_alloc_guard #(
  parameter int unsigned IDX_W = 9
) (
  input  logic             ram_en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] idx_o
);
  assign idx_o = ram_en_i ? {1'b0, idx_i[IDX_W-2:0]} : idx_i;
endmodule

// File: rtl/car_map_top.sv
module car_map_top #(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       ENTRIES    = 512,
  parameter int unsigned       LINE_BYTES = 32,
  parameter int unsigned       LANES      = 8,
  parameter logic [ADDR_W-1:0] WIN_LO     = 32'h7C00_0000,
  parameter logic [ADDR_W-1:0] WIN_HI     = 32'h7FFF_FFFF,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned WSEL_W = OFF_W - LANE_W,
  localparam int unsigned HALF_W = IDX_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ram_en_i,
  input  logic              dbl_mode_i,
  input  logic              idx_mode_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_fetch_i,
  input  logic              req_write_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  output logic              pass_o,
  output logic              hit_o,
  output logic              wr_en_o,
  output logic              ram_way_o,
  output logic [IDX_W-1:0]  ram_idx_o,
  output logic [WSEL_W-1:0] word_sel_o,
  output logic [LANES-1:0]  lane_en_o,
  output logic              fetch_err_o,
  output logic              addr_err_o,
  output logic              cfg_err_o
);
  logic             in_win;
  logic [LANES-1:0] lanes_raw;
  logic             misalign;
  logic [IDX_W-1:0] idx_raw;
  logic             way_raw;
  logic             ram_acc, cfg_bad, hit_d;

  car_win_dec #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
    .addr_i   (req_addr_i),
    .in_win_o (in_win)
  );

  car_lane_gen #(.LANES(LANES)) u_lane (
    .off_i      (req_addr_i[LANE_W-1:0]),
    .size_i     (car_pkg::size_e'(req_size_i)),
    .lane_en_o  (lanes_raw),
    .misalign_o (misalign)
  );

  car_idx_map #(.HALF_W(HALF_W)) u_idx (
    .sel_i (req_addr_i[OFF_W+HALF_W:OFF_W]),
    .dbl_i (dbl_mode_i),
    .idx_o (idx_raw),
    .way_o (way_raw)
  );

  car_alloc_guard #(.IDX_W(IDX_W)) u_alloc (
    .ram_en_i (ram_en_i),
    .idx_i    (alloc_idx_i),
    .idx_o    (alloc_idx_o)
  );

  assign ram_acc = req_valid_i & in_win & ram_en_i;
  assign cfg_bad = ram_en_i & idx_mode_i;
  assign hit_d   = ram_acc & ~cfg_bad & ~req_fetch_i & ~misalign;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_o      <= 1'b0;
      hit_o       <= 1'b0;
      wr_en_o     <= 1'b0;
      ram_way_o   <= 1'b0;
      ram_idx_o   <= '0;
      word_sel_o  <= '0;
      lane_en_o   <= '0;
      fetch_err_o <= 1'b0;
      addr_err_o  <= 1'b0;
      cfg_err_o   <= 1'b0;
    end else begin
      pass_o      <= req_valid_i & ~(in_win & ram_en_i);
      hit_o       <= hit_d;
      wr_en_o     <= hit_d & req_write_i;
      ram_way_o   <= hit_d & way_raw;
      ram_idx_o   <= hit_d ? idx_raw : '0;
      word_sel_o  <= hit_d ? req_addr_i[OFF_W-1:LANE_W] : '0;
      lane_en_o   <= hit_d ? lanes_raw : '0;
      fetch_err_o <= ram_acc & req_fetch_i;
      addr_err_o  <= ram_acc & misalign;
      cfg_err_o   <= cfg_bad;
    end
  end
endmodule

// File: rtl/car_map_chk.sv
module car_map_chk #(
  parameter int unsigned IDX_W = 9,
  parameter int unsigned LANES = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ram_en_i,
  input logic             dbl_mode_i,
  input logic             idx_mode_i,
  input logic             req_valid_i,
  input logic             req_fetch_i,
  input logic [IDX_W-1:0] alloc_idx_i,
  input logic [IDX_W-1:0] alloc_idx_o,
  input logic             pass_o,
  input logic             hit_o,
  input logic             wr_en_o,
  input logic             ram_way_o,
  input logic             ram_idx_msb_i,
  input logic [LANES-1:0] lane_en_o,
  input logic             fetch_err_o,
  input logic             addr_err_o,
  input logic             cfg_err_o
);
  p_alloc_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_i |-> !alloc_idx_o[IDX_W-1]);
  p_alloc_thru_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_en_i |-> alloc_idx_o == alloc_idx_i);
  p_hit_pass_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && pass_o));
  p_hit_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ram_idx_msb_i);
  p_single_way_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !dbl_mode_i) |=> !ram_way_o);
  p_write_lanes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (hit_o && lane_en_o != '0));
  p_err_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_err_o || fetch_err_o || cfg_err_o) |-> (!hit_o && !wr_en_o && lane_en_o == '0));
  p_fetch_nohit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_fetch_i) |=> !hit_o);
  p_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_en_i && idx_mode_i) |=> (cfg_err_o && !hit_o));
  p_off_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_en_i |=> (!hit_o && !fetch_err_o && !addr_err_o && !cfg_err_o));
endmodule

bind car_map_top car_map_chk #(.IDX_W(IDX_W), .LANES(LANES)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ram_en_i      (ram_en_i),
  .dbl_mode_i    (dbl_mode_i),
  .idx_mode_i    (idx_mode_i),
  .req_valid_i   (req_valid_i),
  .req_fetch_i   (req_fetch_i),
  .alloc_idx_i   (alloc_idx_i),
  .alloc_idx_o   (alloc_idx_o),
  .pass_o        (pass_o),
  .hit_o         (hit_o),
  .wr_en_o       (wr_en_o),
  .ram_way_o     (ram_way_o),
  .ram_idx_msb_i (ram_idx_o[IDX_W-1]),
  .lane_en_o     (lane_en_o),
  .fetch_err_o   (fetch_err_o),
  .addr_err_o    (addr_err_o),
  .cfg_err_o     (cfg_err_o)
);

// File: tb/car_map_top_tb_top.sv
module car_map_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ram_en = 1'b0, dbl = 1'b0, idx_mode = 1'b0;
  logic        valid = 1'b0, fetch = 1'b0, write = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = '0;
  logic [8:0]  alloc_in = '0;
  logic [8:0]  alloc_out;
  logic        pass, hit, wr_en, way, fetch_err, addr_err, cfg_err;
  logic [8:0]  idx;
  logic [1:0]  wsel;
  logic [7:0]  lanes;

  int n_checks = 0;
  int n_errors = 0;

  car_map_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ram_en_i(ram_en), .dbl_mode_i(dbl),
    .idx_mode_i(idx_mode), .req_valid_i(valid), .req_addr_i(addr),
    .req_size_i(size), .req_fetch_i(fetch), .req_write_i(write),
    .alloc_idx_i(alloc_in), .alloc_idx_o(alloc_out), .pass_o(pass),
    .hit_o(hit), .wr_en_o(wr_en), .ram_way_o(way), .ram_idx_o(idx),
    .word_sel_o(wsel), .lane_en_o(lanes), .fetch_err_o(fetch_err),
    .addr_err_o(addr_err), .cfg_err_o(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, sample outputs at following negedge
  task automatic access(input logic [31:0] a, input logic [1:0] s,
                        input logic f, input logic w, input logic v);
    logic in_win, racc, cfg, mis, e_hit;
    int nb;
    logic [8:0] e_idx;
    logic [7:0] e_lane;
    string rr;
    valid = v; addr = a; size = s; fetch = f; write = w;
    in_win = (a >= 32'h7C00_0000) && (a <= 32'h7FFF_FFFF);
    racc   = v && in_win && ram_en;
    cfg    = ram_en && idx_mode;
    nb     = 1 << s;
    mis    = (a % nb) != 0;
    e_hit  = racc && !cfg && !f && !mis;
    e_idx  = e_hit ? 9'(256 + ((a >> 5) % 256)) : 9'd0;
    e_lane = e_hit ? 8'(((1 << nb) - 1) << (a % 8)) : 8'd0;
    rr = ram_en ? "R1" : "R10";
    @(negedge clk);
    check(rr, "pass", 64'(pass), 64'(v && !(in_win && ram_en)));
    check(rr, "hit", 64'(hit), 64'(e_hit));
    check("R2", "index", 64'(idx), 64'(e_idx));
    check("R2", "word_sel", 64'(wsel), e_hit ? 64'((a >> 3) % 4) : 64'd0);
    check("R3", "way", 64'(way), (e_hit && dbl) ? 64'((a >> 13) & 1) : 64'd0);
    check("R4", "lanes", 64'(lanes), 64'(e_lane));
    check("R4", "wr_en", 64'(wr_en), 64'(e_hit && w));
    check("R5", "addr_err", 64'(addr_err), 64'(racc && mis));
    check("R6", "fetch_err", 64'(fetch_err), 64'(racc && f));
    check("R7", "cfg_err", 64'(cfg_err), 64'(cfg));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] bases [3];
    int subs [5];
    bases[0] = 32'h7C00_0000; bases[1] = 32'h7E5A_6000; bases[2] = 32'h7FFF_E000;
    subs[0] = 0; subs[1] = 1; subs[2] = 8'h7F; subs[3] = 8'h80; subs[4] = 8'hFF;

    // R9: reset state
    #(CLK_PERIOD * 3 + 1);
    check("R9", "reset hit", 64'(hit), 64'd0);
    check("R9", "reset lanes", 64'(lanes), 64'd0);
    check("R9", "reset idx", 64'(idx), 64'd0);
    check("R9", "reset pass", 64'(pass), 64'd0);
    check("R9", "reset errs", 64'({fetch_err, addr_err, cfg_err}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    ram_en = 1'b1;
    @(negedge clk);

    // R9: one-cycle latency, output unchanged before edge
    valid = 1'b1; addr = 32'h7C00_0000; size = 2'd3; fetch = 1'b0; write = 1'b0;
    #1;
    check("R9", "pre-edge hit", 64'(hit), 64'd0);
    @(negedge clk);
    check("R9", "post-edge hit", 64'(hit), 64'd1);

    // R2 R3 R4 R5 sweep
    for (int d = 0; d < 2; d++) begin
      dbl = d[0];
      for (int b = 0; b < 3; b++)
        for (int k = 0; k < 5; k++)
          for (int s = 0; s < 4; s++)
            for (int o = 0; o < 32; o++)
              access(bases[b] + 32'(subs[k] * 32 + o), 2'(s), 1'b0, 1'((o ^ s) & 1), 1'b1);
    end

    // R3: 16 KB alias in both-way mode, 8 KB in single-way mode
    dbl = 1'b1;
    access(32'h7C00_2040, 2'd2, 1'b0, 1'b1, 1'b1);
    check("R3", "way from bit13", 64'(way), 64'd1);
    access(32'h7C00_4040, 2'd2, 1'b0, 1'b1, 1'b1);
    check("R3", "16KB alias way", 64'(way), 64'd0);
    dbl = 1'b0;
    access(32'h7C00_2040, 2'd2, 1'b0, 1'b1, 1'b1);
    check("R2", "8KB alias idx", 64'(idx), 64'(9'd258));

    // R6: fetches
    for (int s = 0; s < 4; s++) access(32'h7D00_0100, 2'(s), 1'b1, 1'b0, 1'b1);
    access(32'h1000_0000, 2'd2, 1'b1, 1'b0, 1'b1);

    // R1: window edges and outside
    access(32'h7BFF_FFF8, 2'd3, 1'b0, 1'b1, 1'b1);
    access(32'h8000_0000, 2'd3, 1'b0, 1'b1, 1'b1);
    access(32'h7FFF_FFF8, 2'd3, 1'b0, 1'b1, 1'b1);
    access(32'h7FFF_FFF8, 2'd3, 1'b0, 1'b1, 1'b0);

    // R7: config error
    idx_mode = 1'b1;
    access(32'h7C00_0000, 2'd0, 1'b0, 1'b1, 1'b1);
    access(32'h0000_0040, 2'd0, 1'b0, 1'b0, 1'b0);
    idx_mode = 1'b0;

    // R10: RAM disabled
    ram_en = 1'b0;
    idx_mode = 1'b1;
    for (int s = 0; s < 4; s++) access(32'h7E00_0020, 2'(s), 1'b0, 1'b1, 1'b1);
    access(32'h7E00_0021, 2'd1, 1'b1, 1'b0, 1'b1);
    idx_mode = 1'b0;

    // R8: allocation filter
    for (int e = 0; e < 2; e++) begin
      ram_en = e[0];
      for (int i = 0; i < 512; i++) begin
        alloc_in = 9'(i);
        #1;
        check("R8", "alloc idx", 64'(alloc_out), e ? 64'(i % 256) : 64'(i));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule